// File: doc/BRIEF.md
# Square-Wave Tone Discriminator

This block watches a one-bit square-wave input and reports whether it carries a high-pitched or a low-pitched tone. After a two-flop synchronizer, a counter measures every high pulse in clock cycles. When the pulse ends, its width is compared against two limits. A short pulse sets the class bit high. A long pulse clears it. A width between the two limits leaves the bit as it was, which gives the decision hysteresis.

The limits are derived at elaboration from three parameters: the clock frequency, the lowest frequency still treated as high-pitched (4.5 kHz by default) and the highest frequency still treated as low-pitched (1.6 kHz by default). A 10 kHz tone therefore drives the output high and a 1 kHz tone drives it low. Each decision is ready a few cycles after the pulse that produced it. A valid flag reports when at least one full pulse has been measured since reset.

Top module: `tone_discriminator`

## Requirements
- R1: While reset is asserted and after it is released, `tone_hi` and `tone_vld` are both 0 until a complete pulse has been classified.
- R2: The input passes through two flops. A pulse's width is the number of rising clock edges at which the input is sampled high, counting one-cycle pulses.
- R3: A pulse of width at most SHORT_MAX = floor(CLK_HZ / (2*HI_BAND_HZ)) sets `tone_hi` to 1 (111 cycles at CLK_HZ = 1 MHz).
- R4: A pulse of width at least LONG_MIN = ceil(CLK_HZ / (2*LO_BAND_HZ)) sets `tone_hi` to 0 (313 cycles at CLK_HZ = 1 MHz).
- R5: A pulse of width from SHORT_MAX+1 to LONG_MIN-1 leaves `tone_hi` unchanged, but it still counts as a measured pulse.
- R6: `tone_hi` and `tone_vld` change only on the third rising edge after the first edge that samples the input low at the end of a pulse. They hold at all other times.
- R7: `tone_vld` rises with the first classified pulse and stays 1 until the next reset. A pulse already high when reset is released is not measured.
- R8: The width counter is CNT_W = clog2(LONG_MIN+1) bits wide and saturates at its maximum instead of wrapping. A pulse longer than 2^CNT_W-1 cycles is still classed as long.
- R9: Symmetric square waves from 0.625 kHz to 1.6 kHz drive `tone_hi` to 0. Those from 4.5 kHz to 31.25 kHz drive it to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released on a clock edge inside the block |
| tone_in | input | 1 | Raw square-wave input, asynchronous to clk |
| tone_hi | output | 1 | Class bit: 1 for a high-pitched tone, 0 for a low-pitched tone |
| tone_vld | output | 1 | 1 once a complete pulse has been measured since reset |

## Verification
The outputs change exactly three rising edges after the first edge that samples the input low. Two of those edges are the synchronizer and one is the class register. One directed test drives a pulse, then samples at the falling clock edge after the second and after the third of those edges, and expects the old value and then the new value. Every other scenario leaves at least ten low cycles after a pulse before it samples, so each result has settled. Widths are chosen one cycle either side of SHORT_MAX and LONG_MIN, and beyond the counter's range, so that an off-by-one or a wrapping counter changes what the outputs show.

// File: rtl/tone_disc_pkg.sv
package tone_disc_pkg;

  typedef enum logic [1:0] {
    DEC_HOLD  = 2'd0,
    DEC_SHORT = 2'd1,
    DEC_LONG  = 2'd2
  } tdisc_dec_e;

  typedef enum logic {
    CLS_LOW  = 1'b0,
    CLS_HIGH = 1'b1
  } tdisc_cls_e;

  // Widest high half-period still accepted as the high-pitched band.
  function automatic int unsigned short_limit(input int unsigned clk_hz,
                                              input int unsigned band_hz);
    return clk_hz / (2 * band_hz);
  endfunction

  // Narrowest high half-period accepted as the low-pitched band (rounded up).
  function automatic int unsigned long_limit(input int unsigned clk_hz,
                                             input int unsigned band_hz);
    return (clk_hz + 2 * band_hz - 1) / (2 * band_hz);
  endfunction

  function automatic tdisc_dec_e classify(input int unsigned width,
                                          input int unsigned smax,
                                          input int unsigned lmin);
    if (width <= smax)      return DEC_SHORT;
    else if (width >= lmin) return DEC_LONG;
    else                    return DEC_HOLD;
  endfunction

endpackage

// File: rtl/tdisc_sync.sv
module tdisc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg_d;
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign stg_d[i] = d;
    end else begin : g_next
      assign stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/tdisc_width_ctr.sv
module tdisc_width_ctr #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             lvl,
  output logic             pulse_done,
  output logic [CNT_W-1:0] pulse_w
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             counting;

  // Counting starts only after a low level has been seen, so a pulse in
  // progress at reset release is never measured.
  always_comb begin
    counting = lvl & armed_q;
    armed_d  = armed_q | ~lvl;
    cnt_en   = counting | (cnt_q != '0);
    if (counting) begin
      cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign pulse_done = ~lvl & (cnt_q != '0);
  assign pulse_w    = cnt_q;

endmodule

// File: rtl/tdisc_classifier.sv
module tdisc_classifier
  import tone_disc_pkg::*;
#(
  parameter int unsigned CNT_W     = 9,
  parameter int unsigned SHORT_MAX = 111,
  parameter int unsigned LONG_MIN  = 313
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             pulse_done,
  input  logic [CNT_W-1:0] pulse_w,
  output logic             cls_hi,
  output logic             cls_vld
);

  tdisc_dec_e dec;
  tdisc_cls_e cls_q, cls_d;
  logic       vld_q, vld_d;
  logic       upd_en;

  always_comb begin
    dec    = classify(32'(pulse_w), SHORT_MAX, LONG_MIN);
    upd_en = pulse_done;
    vld_d  = 1'b1;
    unique case (dec)
      DEC_SHORT: cls_d = CLS_HIGH;
      DEC_LONG:  cls_d = CLS_LOW;
      default:   cls_d = cls_q;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cls_q <= CLS_LOW;
      vld_q <= 1'b0;
    end else if (upd_en) begin
      cls_q <= cls_d;
      vld_q <= vld_d;
    end
  end

  assign cls_hi  = (cls_q == CLS_HIGH);
  assign cls_vld = vld_q;

endmodule

// File: rtl/tone_discriminator.sv
module tone_discriminator
  import tone_disc_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned HI_BAND_HZ  = 4500,
  parameter int unsigned LO_BAND_HZ  = 1600,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tone_in,
  output logic tone_hi,
  output logic tone_vld
);

  localparam int unsigned SHORT_MAX = short_limit(CLK_HZ, HI_BAND_HZ);
  localparam int unsigned LONG_MIN  = long_limit(CLK_HZ, LO_BAND_HZ);
  localparam int unsigned CNT_W     = $clog2(LONG_MIN + 1);

  logic             rst_sync_n;
  logic             tone_s;
  logic             pulse_done;
  logic [CNT_W-1:0] pulse_w;

  tdisc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .d      (1'b1),
    .q      (rst_sync_n)
  );

  // Synchronizer resets to 1 so a level already high at release reads as a
  // pulse in progress rather than a fresh rising edge.
  tdisc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_in_sync (
    .clk    (clk),
    .arst_n (rst_sync_n),
    .d      (tone_in),
    .q      (tone_s)
  );

  tdisc_width_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .arst_n     (rst_sync_n),
    .lvl        (tone_s),
    .pulse_done (pulse_done),
    .pulse_w    (pulse_w)
  );

  tdisc_classifier #(
    .CNT_W     (CNT_W),
    .SHORT_MAX (SHORT_MAX),
    .LONG_MIN  (LONG_MIN)
  ) u_cls (
    .clk        (clk),
    .arst_n     (rst_sync_n),
    .pulse_done (pulse_done),
    .pulse_w    (pulse_w),
    .cls_hi     (tone_hi),
    .cls_vld    (tone_vld)
  );

endmodule

// File: rtl/tone_discriminator_chk.sv
module tone_discriminator_chk #(
  parameter int unsigned CNT_W     = 9,
  parameter int unsigned SHORT_MAX = 111,
  parameter int unsigned LONG_MIN  = 313
) (
  input logic             clk,
  input logic             rst_ns,
  input logic             tone_hi,
  input logic             tone_vld,
  input logic             pulse_done,
  input logic [CNT_W-1:0] pulse_w
);

  localparam logic [CNT_W-1:0] W_SMAX = CNT_W'(SHORT_MAX);
  localparam logic [CNT_W-1:0] W_LMIN = CNT_W'(LONG_MIN);
  localparam logic [CNT_W-1:0] W_MAX  = '1;

  always @(posedge clk) begin
    if (!rst_ns) begin
      p_reset_idle_r1: assert (!tone_hi && !tone_vld)
        else $error("outputs not idle during reset");
    end
  end

  p_short_high_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (pulse_done && pulse_w <= W_SMAX) |=> tone_hi);

  p_long_low_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (pulse_done && pulse_w >= W_LMIN) |=> !tone_hi);

  p_band_hold_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (pulse_done && pulse_w > W_SMAX && pulse_w < W_LMIN) |=> $stable(tone_hi));

  p_quiet_stable_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    !pulse_done |=> ($stable(tone_hi) && $stable(tone_vld)));

  p_vld_set_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    pulse_done |=> tone_vld);

  p_vld_sticky_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    tone_vld |=> tone_vld);

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (pulse_w == W_MAX) |=> (pulse_w == W_MAX || pulse_w == '0));

endmodule

bind tone_discriminator tone_discriminator_chk #(
  .CNT_W     (CNT_W),
  .SHORT_MAX (SHORT_MAX),
  .LONG_MIN  (LONG_MIN)
) u_chk (
  .clk        (clk),
  .rst_ns     (rst_sync_n),
  .tone_hi    (tone_hi),
  .tone_vld   (tone_vld),
  .pulse_done (pulse_done),
  .pulse_w    (pulse_w)
);

// File: tb/tone_discriminator_tb.sv
`timescale 1ns/1ps
module tone_discriminator_tb;

  localparam int CLK_HZ = 1_000_000;
  localparam int SMAX   = CLK_HZ / (2 * 4500);                // 111
  localparam int LMIN   = (CLK_HZ + 2 * 1600 - 1) / (2 * 1600); // 313

  logic clk;
  logic rst_n;
  logic tone_in;
  logic tone_hi;
  logic tone_vld;

  int n_chk;
  int n_err;
  bit finished;

  tone_discriminator #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tone_in  (tone_in),
    .tone_hi  (tone_hi),
    .tone_vld (tone_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic pulse(input int hi_w, input int lo_w);
    @(negedge clk);
    tone_in = 1'b1;
    repeat (hi_w) @(negedge clk);
    tone_in = 1'b0;
    repeat (lo_w - 1) @(negedge clk);
  endtask

  task automatic burst(input int hi_w, input int lo_w, input int n);
    for (int i = 0; i < n; i++) pulse(hi_w, lo_w);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tone_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "tone_hi in reset", tone_hi, 1'b0);
    chk("R1", "tone_vld in reset", tone_vld, 1'b0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1", "tone_hi after reset", tone_hi, 1'b0);
    chk("R1", "tone_vld after reset", tone_vld, 1'b0);
  endtask

  task automatic t_partial_pulse();
    @(negedge clk);
    rst_n = 1'b0;
    tone_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    tone_in = 1'b0;
    repeat (12) @(negedge clk);
    chk("R7", "vld after pulse spanning reset", tone_vld, 1'b0);
    chk("R7", "hi after pulse spanning reset", tone_hi, 1'b0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    tone_in = 1'b1;
    repeat (50) @(negedge clk);
    tone_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R6", "hi one edge after low", tone_hi, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R6", "hi two edges after low (R2 sync)", tone_hi, 1'b0);
    chk("R6", "vld two edges after low", tone_vld, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R6", "hi three edges after low (R3)", tone_hi, 1'b1);
    chk("R7", "vld set by first pulse", tone_vld, 1'b1);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_bounds();
    pulse(SMAX + 1, 12);
    chk("R5", "width SMAX+1 holds high", tone_hi, 1'b1);
    pulse(LMIN - 1, 12);
    chk("R5", "width LMIN-1 holds high", tone_hi, 1'b1);
    pulse(LMIN, 12);
    chk("R4", "width LMIN clears", tone_hi, 1'b0);
    pulse(LMIN - 1, 12);
    chk("R5", "width LMIN-1 holds low", tone_hi, 1'b0);
    pulse(SMAX + 1, 12);
    chk("R5", "width SMAX+1 holds low", tone_hi, 1'b0);
    chk("R7", "vld stays set", tone_vld, 1'b1);
    pulse(SMAX, 12);
    chk("R3", "width SMAX sets", tone_hi, 1'b1);
    pulse(LMIN + 40, 12);
    chk("R4", "long pulse clears", tone_hi, 1'b0);
    pulse(1, 12);
    chk("R2", "one-cycle pulse sets", tone_hi, 1'b1);
  endtask

  task automatic t_saturate();
    pulse(600, 12);
    chk("R8", "600-cycle pulse clears", tone_hi, 1'b0);
    pulse(20, 12);
    chk("R3", "short pulse sets", tone_hi, 1'b1);
    pulse(520, 12);
    chk("R8", "520-cycle pulse clears", tone_hi, 1'b0);
  endtask

  task automatic t_tones();
    burst(50, 50, 5);
    chk("R9", "10 kHz tone", tone_hi, 1'b1);
    burst(500, 500, 3);
    chk("R9", "1 kHz tone", tone_hi, 1'b0);
    burst(16, 16, 6);
    chk("R9", "31.25 kHz tone", tone_hi, 1'b1);
    burst(800, 800, 2);
    chk("R9", "0.625 kHz tone", tone_hi, 1'b0);
    burst(100, 100, 4);
    chk("R9", "5 kHz tone", tone_hi, 1'b1);
    burst(320, 320, 3);
    chk("R9", "1.5625 kHz tone", tone_hi, 1'b0);
    chk("R7", "vld still set", tone_vld, 1'b1);
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    finished = 1'b0;
    rst_n = 1'b1;
    tone_in = 1'b0;
    #1 rst_n = 1'b0;
    t_reset();
    t_partial_pulse();
    t_latency();
    t_bounds();
    t_saturate();
    t_tones();
    t_reset();
    finish_run();
  end

  initial begin
    repeat (100_000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule